// File: doc/BRIEF.md
# One-Second Error Performance Counters

This block keeps two 14-bit error tallies for a framed line receiver. The first is the fault tally. While multiframe alignment is not held, it counts errored frame-alignment bits. Once alignment is held, it counts errored CRC blocks. The second tally counts received errored E bits, and only while multiframe alignment is held. Error detection is done elsewhere. This block receives single-cycle event pulses and counts them.

Each tally is read as two byte-wide registers. The low register carries count bits 6:0 and the high register carries bits 13:7. Bit 7 of every register always reads 1. The mode input selects one of two behaviours:

- **Snapshot mode:** a one-second tick copies each live tally into its registers and restarts the tally.
- **Polling mode:** reading the low byte shows the live low bits and freezes the high half. Reading the high byte returns the frozen half and then clears the tally.

Top module: `err_perf_counters`

## Requirements
- R1: After reset, all four registers (address 0 fault low, 1 fault high, 2 E-bit low, 3 E-bit high) read 8'h80.
- R2: A register reads {1'b1, 7 count bits}. The low register holds count bits 6:0 and the high register holds bits 13:7.
- R3: With poll_mode_i=0, the registers take the live count at each cycle where sec_tick_i=1, and the live count restarts from zero.
- R4: With mf_locked_i=0, the fault tally counts fas_err_i pulses and ignores crc_err_i.
- R5: With mf_locked_i=1, the fault tally counts crc_err_i pulses and ignores fas_err_i.
- R6: The E-bit tally counts ebit_err_i pulses only while mf_locked_i=1.
- R7: A tally saturates at 16383 and does not wrap.
- R8: With poll_mode_i=1, a read of a low register returns the live low bits and latches the high half. A following read of the high register returns the latched half and clears the tally. sec_tick_i has no effect in this mode.
- R9: An event in the same cycle as a snapshot or clear counts toward the new period.
- R10: In snapshot mode, the registers keep their value between ticks, and reads have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| poll_mode_i | input | 1 | 0 = snapshot each second, 1 = clear on access |
| mf_locked_i | input | 1 | Multiframe alignment held |
| fas_err_i | input | 1 | Errored frame-alignment bit pulse |
| crc_err_i | input | 1 | Errored CRC block pulse |
| ebit_err_i | input | 1 | Errored E bit pulse |
| sec_tick_i | input | 1 | One-cycle pulse each second |
| rd_en_i | input | 1 | Register read strobe, acts at the clock edge |
| rd_addr_i | input | 2 | Register select |
| rd_data_o | output | 8 | Selected register, combinational on rd_addr_i |

## Verification
The assertions assume that each event input is a level sampled once per clock, so that a high input for N cycles means N events. They also assume that poll_mode_i changes only while no read or tick is in flight. The stimulus sets the mode between scenarios and keeps it stable while events, reads and ticks are applied. Reads are single-cycle strobes with no coincident events, except where coincidence is the point of the test. The only coincidence tested is an event arriving on a tick.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  typedef enum logic [1:0] {
    REG_FLT_LO = 2'd0,
    REG_FLT_HI = 2'd1,
    REG_EB_LO  = 2'd2,
    REG_EB_HI  = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_FLT = 0;
  localparam int unsigned CH_EB  = 1;
endpackage

// File: rtl/err_sat_counter.sv
module err_sat_counter #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;

  // a clear restarts the period, and an event in the clear cycle lands in it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= {{(W-1){1'b0}}, inc_i};
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX) else $error("wrap");  // R7
  AST_CLR_NEW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == W'($past(inc_i))) else $error("clr");  // R9
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + 1'b1) else $error("step");  // R4
endmodule

// File: rtl/err_cnt_chan.sv
module err_cnt_chan #(
  parameter int unsigned CNT_W  = 14,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              tick_i,
  input  logic              inc_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  snap_q;
  logic [HALF_W-1:0] hi_hold_q;
  logic              clr;

  assign clr = poll_i ? rd_hi_i : tick_i;

  err_sat_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc_i),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      hi_hold_q <= '0;
    end else begin
      if (!poll_i && tick_i) snap_q <= cnt;
      // freeze upper half when the low byte goes out
      if (poll_i && rd_lo_i) hi_hold_q <= cnt[CNT_W-1:HALF_W];
    end
  end

  assign lo_o = poll_i ? cnt[HALF_W-1:0] : snap_q[HALF_W-1:0];
  assign hi_o = poll_i ? hi_hold_q       : snap_q[CNT_W-1:HALF_W];

  AST_SNAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!poll_i && tick_i) |=> snap_q == $past(cnt)) else $error("snap");  // R3
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!poll_i && !tick_i) |=> $stable(snap_q)) else $error("hold");  // R10
  AST_HI_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && rd_lo_i) |=> hi_hold_q == $past(cnt[CNT_W-1:HALF_W])) else $error("latch");  // R8
endmodule

// File: rtl/err_perf_counters.sv
module err_perf_counters
  import err_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 14,
  localparam int unsigned HALF_W = CNT_W / 2,
  localparam int unsigned DW     = HALF_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          poll_mode_i,
  input  logic          mf_locked_i,
  input  logic          fas_err_i,
  input  logic          crc_err_i,
  input  logic          ebit_err_i,
  input  logic          sec_tick_i,
  input  logic          rd_en_i,
  input  logic [1:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [NUM_CH-1:0] inc;
  logic [HALF_W-1:0] lo [NUM_CH];
  logic [HALF_W-1:0] hi [NUM_CH];

  // fault source follows multiframe state; E bits only count when aligned
  assign inc[CH_FLT] = mf_locked_i ? crc_err_i : fas_err_i;
  assign inc[CH_EB]  = mf_locked_i & ebit_err_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic rd_lo, rd_hi;
    assign rd_lo = rd_en_i && rd_addr_i == 2'(2*c);
    assign rd_hi = rd_en_i && rd_addr_i == 2'(2*c + 1);

    err_cnt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .poll_i  (poll_mode_i),
      .tick_i  (sec_tick_i),
      .inc_i   (inc[c]),
      .rd_lo_i (rd_lo),
      .rd_hi_i (rd_hi),
      .lo_o    (lo[c]),
      .hi_o    (hi[c])
    );
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr_i))
      REG_FLT_LO: rd_data_o = {1'b1, lo[CH_FLT]};
      REG_FLT_HI: rd_data_o = {1'b1, hi[CH_FLT]};
      REG_EB_LO:  rd_data_o = {1'b1, lo[CH_EB]};
      default:    rd_data_o = {1'b1, hi[CH_EB]};
    endcase
  end

  AST_TOP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DW-1]) else $error("top bit");  // R2
endmodule

// File: tb/tb_err_perf_counters.sv
module tb_err_perf_counters;
  logic clk = 1'b0, rst_n = 1'b0;
  logic poll = 0, mf = 0, fas = 0, crc = 0, eb = 0, tick = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  err_perf_counters dut (
    .clk_i(clk), .rst_ni(rst_n), .poll_mode_i(poll), .mf_locked_i(mf),
    .fas_err_i(fas), .crc_err_i(crc), .ebit_err_i(eb), .sec_tick_i(tick),
    .rd_en_i(rd_en), .rd_addr_i(addr), .rd_data_o(rd_data)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  // read one register: the value is sampled before the edge where the access acts
  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data, exp);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input bit f, input bit c, input bit e, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fas = f; crc = c; eb = e;
    end
    @(negedge clk);
    fas = 0; crc = 0; eb = 0;
  endtask

  task automatic do_tick(input bit with_crc);
    @(negedge clk);
    tick = 1; crc = with_crc;
    @(negedge clk);
    tick = 0; crc = 0;
  endtask

  task automatic t_reset();
    rd_chk(0, 8'h80, "R1"); rd_chk(1, 8'h80, "R1");
    rd_chk(2, 8'h80, "R1"); rd_chk(3, 8'h80, "R1");
  endtask

  task automatic t_fas_source();
    mf = 0;
    pulse(1, 0, 0, 5);
    pulse(0, 1, 0, 3);
    pulse(0, 0, 1, 4);
    rd_chk(0, 8'h80, "R10");
    do_tick(0);
    rd_chk(0, 8'h85, "R4");
    rd_chk(1, 8'h80, "R2");
    rd_chk(2, 8'h80, "R6");
    rd_chk(0, 8'h85, "R10");
  endtask

  task automatic t_crc_source();
    mf = 1;
    pulse(0, 1, 0, 200);
    pulse(1, 0, 0, 3);
    pulse(0, 0, 1, 9);
    do_tick(1);
    rd_chk(0, 8'hC8, "R5");
    rd_chk(1, 8'h81, "R2");
    rd_chk(2, 8'h89, "R6");
    rd_chk(3, 8'h80, "R2");
    do_tick(0);
    rd_chk(0, 8'h81, "R9");
    rd_chk(2, 8'h80, "R3");
  endtask

  task automatic t_saturate();
    mf = 0;
    pulse(1, 0, 0, 16400);
    do_tick(0);
    rd_chk(0, 8'hFF, "R7");
    rd_chk(1, 8'hFF, "R7");
    do_tick(0);
    rd_chk(0, 8'h80, "R3");
    rd_chk(1, 8'h80, "R3");
  endtask

  task automatic t_poll();
    poll = 1; mf = 1;
    pulse(0, 1, 0, 130);
    rd_chk(0, 8'h82, "R8");
    pulse(0, 1, 0, 127);
    rd_chk(1, 8'h81, "R8");
    rd_chk(0, 8'h80, "R8");
    pulse(0, 1, 0, 3);
    do_tick(0);
    rd_chk(0, 8'h83, "R8");
    rd_chk(1, 8'h80, "R8");
    pulse(0, 0, 1, 5);
    rd_chk(2, 8'h85, "R8");
    rd_chk(3, 8'h80, "R8");
    rd_chk(2, 8'h80, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fas_source();
    t_crc_source();
    t_saturate();
    t_poll();
    report();
  end
endmodule